// File: doc/BRIEF.md
# Three-Wire Serial Slave with Clock-Stretch Wait

This block is a byte-oriented synchronous serial slave for a three-wire link made of a clock line, an open-drain data line and an active-low enable line. The link is live only while the enable is low. Every SCL falling edge captures one incoming bit. The outgoing bit is presented through an open-drain pulldown and changes shortly after each falling edge. Both directions shift most significant bit first through one shared shift register, so each byte is exchanged in both directions at once.

After each full byte the slave hands the received byte to a one-entry receive buffer and takes the next outgoing byte from a one-entry transmit buffer, in a single step. If either buffer cannot take part (the receive side is still full, or no transmit byte is waiting), the slave holds SCL low once the master has raised it, after a programmable delay. This wait stalls the master, which must release SCL and poll it until the slave lets go.

All three lines are oversampled by a fast system clock through a synchronizer chain before edges are detected. Inside the chip the block offers a byte-wide valid/ready receive port and a byte-wide valid/ready transmit port.

Top module: `s3w_slave`

## Requirements
- R1: While reset is high and in the first cycle after it, `scl_pull` and `sda_pull` are 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: Incoming bits are sampled on SCL falling edges, most significant bit first. After the eighth falling edge of a byte, the byte appears on `rx_data` with `rx_valid` = 1 once the handoff takes place.
- R3: Outgoing bits leave most significant bit first. A 0 bit drives `sda_pull` = 1 and a 1 bit leaves it at 0. The first bit is presented after the enable falls, and each following bit after an SCL falling edge.
- R4: A wait (`scl_pull` = 1) starts only after a complete byte, and only if at that point the receive buffer is full or the transmit buffer is empty. With both buffers ready, no wait occurs.
- R5: While `rx_valid` = 1 and `rx_ready` = 0, `rx_valid` stays 1 and `rx_data` holds its value.
- R6: The handoff takes place in the first clock in which the receive buffer is empty and a transmit byte is held. The SCL wait ends in that same clock edge. Seen from the ports, `scl_pull` is 0 two clocks after a one-cycle `rx_ready` pulse or a one-cycle `tx_valid` pulse that unblocks the wait.
- R7: When a wait is due, `scl_pull` rises exactly WAIT_DLY + SYNC_STAGES + 1 system clocks after SCL returns high following the byte's last falling edge.
- R8: Both enable edges clear the bit counter. A rising enable abandons a partial byte, discards a byte still waiting for handoff, and ends any SCL wait within SYNC_STAGES + 2 clocks.
- R9: `sda_pull` is 0 while the enable is high, and also between the end of a byte and its handoff. If no transmit byte is held when the enable falls, the first byte sent is all ones.
- R10: The transmit buffer holds one byte. `tx_ready` goes to 0 the clock after a byte is accepted, and returns to 1 when that byte moves into the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Level seen on the SCL line |
| scl_pull | output | 1 | 1 pulls SCL low (wait condition) |
| sda_in | input | 1 | Level seen on the SDA line |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain data out) |
| en_n | input | 1 | Active-low enable framing each transfer |
| rx_data | output | BYTE_W | Received byte |
| rx_valid | output | 1 | Received byte present |
| rx_ready | input | 1 | Consumer takes the received byte |
| tx_data | input | BYTE_W | Byte to send |
| tx_valid | input | 1 | Producer offers a byte to send |
| tx_ready | output | 1 | Transmit buffer empty |

## Verification
Write-only bytes (0xA5, 0x01, 0x11, 0x22, 0x66, 0x9C), sent while the slave sends all ones, show that capture is MSB first and tied to falling edges. Read-only bytes (0x3C, 0xC3), sent while the master sends all ones, show output order and open-drain polarity. Stalls are forced once by a full receive buffer and once by an empty transmit buffer, which tells the two wait causes apart. The release cycle after each unblocking pulse and the exact wait onset delay are both measured. An enable pulse in the middle of a byte, and another during a wait, show that the bit counter is cleared and that the wait ends on abort.

// File: rtl/s3w_pkg.sv
package s3w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PEND  = 2'd2,
        ST_STALL = 2'd3
    } s3w_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic en_n;
    } s3w_lines_t;

    typedef struct packed {
        logic scl_fall;
        logic scl_rise;
        logic en_fall;
        logic en_rise;
        logic sda;
    } s3w_evt_t;

    localparam s3w_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1, en_n: 1'b1};

    function automatic logic byte_waiting(s3w_state_e s);
        return (s == ST_PEND) || (s == ST_STALL);
    endfunction

endpackage

// File: rtl/s3w_front.sv
module s3w_front
    import s3w_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  s3w_lines_t raw,
    output s3w_evt_t   ev
);
    localparam int TOP = STAGES - 1;

    s3w_lines_t [TOP:0] stg;
    s3w_lines_t         last;
    s3w_lines_t         cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= {STAGES{LINES_IDLE}};
            last <= LINES_IDLE;
        end else begin
            for (int i = TOP; i > 0; i--) begin
                stg[i] <= stg[i-1];
            end
            stg[0] <= raw;
            last   <= stg[TOP];
        end
    end

    assign cur         = stg[TOP];
    assign ev.scl_fall = last.scl & ~cur.scl;
    assign ev.scl_rise = ~last.scl & cur.scl;
    assign ev.en_fall  = last.en_n & ~cur.en_n;
    assign ev.en_rise  = ~last.en_n & cur.en_n;
    assign ev.sda      = cur.sda;

endmodule

// File: rtl/s3w_buf.sv
module s3w_buf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_take,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            tx_byte  <= '0;
            tx_full  <= 1'b0;
        end else begin
            if (rx_push) begin
                rx_data  <= rx_byte;
                rx_valid <= 1'b1;
            end else if (rx_valid && rx_ready) begin
                rx_valid <= 1'b0;
            end
            if (tx_valid && !tx_full) begin
                tx_byte <= tx_data;
                tx_full <= 1'b1;
            end else if (tx_take) begin
                tx_full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/s3w_ctrl.sv
module s3w_ctrl
    import s3w_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int WAIT_DLY = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  s3w_evt_t          ev,
    input  logic              rx_space,
    input  logic              tx_avail,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_take,
    output logic              scl_pull,
    output logic              sda_pull
);
    localparam int BIT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam int CNT_W = $clog2(WAIT_DLY + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(WAIT_DLY - 1);

    s3w_state_e        st;
    logic [BYTE_W-1:0] sh;
    logic [BIT_W-1:0]  nbit;
    logic              run;
    logic [CNT_W-1:0]  cnt;
    logic              handoff;

    assign handoff  = byte_waiting(st) && rx_space && tx_avail && !ev.en_rise;
    assign rx_push  = handoff;
    assign rx_byte  = sh;
    assign tx_take  = handoff || (ev.en_fall && tx_avail);
    assign scl_pull = (st == ST_STALL);
    assign sda_pull = (st == ST_SHIFT) && !sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            sh   <= '1;
            nbit <= '0;
            run  <= 1'b0;
            cnt  <= '0;
        end else if (ev.en_rise) begin
            st   <= ST_IDLE;
            sh   <= '1;
            nbit <= '0;
            run  <= 1'b0;
        end else if (ev.en_fall) begin
            st   <= ST_SHIFT;
            sh   <= tx_avail ? tx_byte : '1;
            nbit <= '0;
            run  <= 1'b0;
        end else begin
            unique case (st)
                ST_SHIFT: begin
                    if (ev.scl_fall) begin
                        sh <= {sh[BYTE_W-2:0], ev.sda};
                        if (nbit == LAST_BIT) begin
                            nbit <= '0;
                            st   <= ST_PEND;
                        end else begin
                            nbit <= nbit + BIT_W'(1);
                        end
                    end
                end
                ST_PEND: begin
                    if (handoff) begin
                        st  <= ST_SHIFT;
                        sh  <= tx_byte;
                        run <= 1'b0;
                    end else if (ev.scl_rise) begin
                        run <= 1'b1;
                        cnt <= '0;
                    end else if (run) begin
                        if (cnt == CNT_END) begin
                            st  <= ST_STALL;
                            run <= 1'b0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_STALL: begin
                    if (handoff) begin
                        st <= ST_SHIFT;
                        sh <= tx_byte;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/s3w_slave.sv
module s3w_slave
    import s3w_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_DLY    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    output logic              scl_pull,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              en_n,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);
    s3w_lines_t        lines;
    s3w_evt_t          ev;
    logic              rx_push;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_take;
    logic [BYTE_W-1:0] tx_byte;
    logic              tx_full;

    assign lines = '{scl: scl_in, sda: sda_in, en_n: en_n};

    s3w_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk (clk),
        .rst (rst),
        .raw (lines),
        .ev  (ev)
    );

    s3w_ctrl #(.BYTE_W(BYTE_W), .WAIT_DLY(WAIT_DLY)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rx_space (!rx_valid),
        .tx_avail (tx_full),
        .tx_byte  (tx_byte),
        .rx_push  (rx_push),
        .rx_byte  (rx_byte),
        .tx_take  (tx_take),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull)
    );

    s3w_buf #(.BYTE_W(BYTE_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .rx_push  (rx_push),
        .rx_byte  (rx_byte),
        .rx_ready (rx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_take  (tx_take),
        .tx_byte  (tx_byte),
        .tx_full  (tx_full)
    );

    assign tx_ready = !tx_full;

endmodule

// File: rtl/s3w_slave_chk.sv
module s3w_slave_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_pull,
    input logic              sda_pull,
    input logic [BYTE_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!scl_pull && !sda_pull && !rx_valid && tx_ready));

    p_rx_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    p_tx_full_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_stall_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull) |-> ($past(rx_valid) || $past(tx_ready)));

    p_sda_free_in_wait_r9: assert property (@(posedge clk) disable iff (rst)
        scl_pull |-> !sda_pull);

endmodule

bind s3w_slave s3w_slave_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready)
);

// File: tb/s3w_slave_bench.sv
module s3w_slave_bench;
    localparam int CLK_P    = 10;
    localparam int WAIT_DLY = 12;
    localparam int SYNC     = 2;
    localparam int H        = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       en_n = 1'b1;
    logic       rx_ready = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       scl_pull, sda_pull, rx_valid, tx_ready;
    logic [7:0] rx_data;
    logic       scl_bus, sda_bus;

    int n_tests = 0;
    int n_fail  = 0;

    assign scl_bus = m_scl & ~scl_pull;
    assign sda_bus = m_sda & ~sda_pull;

    always #(CLK_P/2) clk = ~clk;

    s3w_slave #(.BYTE_W(8), .SYNC_STAGES(SYNC), .WAIT_DLY(WAIT_DLY)) u_s3w_slave (
        .clk(clk), .rst(rst), .scl_in(scl_bus), .scl_pull(scl_pull),
        .sda_in(sda_bus), .sda_pull(sda_pull), .en_n(en_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1; en_n = 1'b1;
        rx_ready = 1'b0; tx_valid = 1'b0;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
    endtask

    task automatic push_tx(input logic [7:0] v);
        tx_valid = 1'b1; tx_data = v;
        wait_clk(1);
        tx_valid = 1'b0;
        wait_clk(1);
    endtask

    task automatic pop_rx();
        rx_ready = 1'b1;
        wait_clk(1);
        rx_ready = 1'b0;
        wait_clk(1);
    endtask

    task automatic frame_begin();
        en_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
        mi = '1;
        for (int i = 7; i > 7 - nbits; i--) begin
            m_sda = mo[i];
            wait_clk(H);
            mi[i] = sda_bus;
            m_scl = 1'b0;
            wait_clk(H);
            m_scl = 1'b1;
        end
        m_sda = 1'b1;
    endtask

    task automatic settle(output bit saw);
        saw = 1'b0;
        repeat (WAIT_DLY + 10) begin
            @(negedge clk);
            if (scl_pull) saw = 1'b1;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "scl_pull after reset", scl_pull, 0);
        check("R1", "sda_pull after reset", sda_pull, 0);
        check("R1", "rx_valid after reset", rx_valid, 0);
        check("R1", "tx_ready after reset", tx_ready, 1);
    endtask

    task automatic t_write();
        logic [7:0] mi;
        bit saw;
        do_reset();
        push_tx(8'hFF);
        frame_begin();
        push_tx(8'hFF);
        xfer(8'hA5, 8, mi);
        settle(saw);
        check("R4", "no wait with buffers ready", saw, 0);
        check("R2", "rx byte A5", rx_data, 8'hA5);
        check("R2", "rx_valid", rx_valid, 1);
        pop_rx();
        push_tx(8'hFF);
        xfer(8'h01, 8, mi);
        settle(saw);
        check("R2", "rx byte 01", rx_data, 8'h01);
        check("R4", "no wait second byte", saw, 0);
        en_n = 1'b1; wait_clk(H);
    endtask

    task automatic t_read();
        logic [7:0] mi;
        bit saw;
        do_reset();
        push_tx(8'h3C);
        frame_begin();
        push_tx(8'hC3);
        xfer(8'hFF, 8, mi);
        settle(saw);
        check("R3", "read byte 3C", mi, 8'h3C);
        check("R3", "wired rx of read byte", rx_data, 8'h3C);
        pop_rx();
        push_tx(8'hFF);
        xfer(8'hFF, 8, mi);
        settle(saw);
        check("R3", "read byte C3", mi, 8'hC3);
        en_n = 1'b1; wait_clk(H);
        check("R9", "sda released with enable high", sda_pull, 0);
    endtask

    task automatic t_no_tx();
        logic [7:0] mi;
        bit saw;
        do_reset();
        frame_begin();
        check("R9", "no pulldown without tx byte", sda_pull, 0);
        push_tx(8'h00);
        xfer(8'hFF, 8, mi);
        settle(saw);
        check("R9", "all ones sent without tx byte", mi, 8'hFF);
        en_n = 1'b1; wait_clk(H);
    endtask

    task automatic t_rx_full();
        logic [7:0] mi;
        bit saw;
        do_reset();
        push_tx(8'hFF);
        frame_begin();
        push_tx(8'hFF);
        xfer(8'h11, 8, mi);
        settle(saw);
        check("R2", "first byte 11", rx_data, 8'h11);
        push_tx(8'hFF);
        xfer(8'h22, 8, mi);
        settle(saw);
        check("R4", "wait while rx full", scl_pull, 1);
        check("R4", "SCL line held low", scl_bus, 0);
        check("R5", "rx byte held during wait", rx_data, 8'h11);
        check("R9", "sda released during wait", sda_pull, 0);
        rx_ready = 1'b1;
        wait_clk(1);
        rx_ready = 1'b0;
        check("R6", "still waiting one clock after pop", scl_pull, 1);
        wait_clk(1);
        check("R6", "wait released two clocks after pop", scl_pull, 0);
        check("R6", "new byte handed off", rx_data, 8'h22);
        check("R6", "rx_valid after handoff", rx_valid, 1);
        en_n = 1'b1; wait_clk(H);
    endtask

    task automatic t_tx_empty();
        logic [7:0] mi;
        bit saw;
        do_reset();
        push_tx(8'hFF);
        frame_begin();
        check("R10", "tx buffer drained into shifter", tx_ready, 1);
        xfer(8'h66, 8, mi);
        settle(saw);
        check("R4", "wait while tx empty", scl_pull, 1);
        check("R4", "no handoff during wait", rx_valid, 0);
        tx_valid = 1'b1; tx_data = 8'hFF;
        wait_clk(1);
        tx_valid = 1'b0;
        check("R10", "tx_ready low while full", tx_ready, 0);
        check("R6", "still waiting one clock after tx", scl_pull, 1);
        wait_clk(1);
        check("R6", "wait released two clocks after tx", scl_pull, 0);
        check("R10", "tx_ready back after load", tx_ready, 1);
        check("R6", "byte 66 handed off", rx_data, 8'h66);
        en_n = 1'b1; wait_clk(H);
    endtask

    task automatic t_wait_delay();
        logic [7:0] mi;
        int k;
        do_reset();
        push_tx(8'hFF);
        frame_begin();
        xfer(8'h77, 8, mi);
        k = 0;
        while (!scl_pull && k < 200) begin
            @(negedge clk);
            k++;
        end
        check("R7", "wait onset clocks", k, WAIT_DLY + SYNC + 1);
        en_n = 1'b1; wait_clk(H);
    endtask

    task automatic t_abort();
        logic [7:0] mi;
        bit saw;
        do_reset();
        push_tx(8'hFF);
        frame_begin();
        push_tx(8'hFF);
        xfer(8'h00, 3, mi);
        en_n = 1'b1; wait_clk(H);
        check("R8", "partial byte dropped", rx_valid, 0);
        frame_begin();
        push_tx(8'hFF);
        xfer(8'h9C, 8, mi);
        settle(saw);
        check("R8", "bit counter cleared by enable", rx_data, 8'h9C);
        check("R8", "byte after abort valid", rx_valid, 1);
        en_n = 1'b1; wait_clk(H);
    endtask

    task automatic t_abort_stall();
        logic [7:0] mi;
        bit saw;
        do_reset();
        push_tx(8'hFF);
        frame_begin();
        xfer(8'h44, 8, mi);
        settle(saw);
        check("R4", "wait before abort", scl_pull, 1);
        en_n = 1'b1;
        wait_clk(SYNC + 2);
        check("R8", "enable high ends wait", scl_pull, 0);
        check("R8", "pending byte discarded", rx_valid, 0);
        wait_clk(H);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_read();
        t_no_tx();
        t_rx_full();
        t_tx_empty();
        t_wait_delay();
        t_abort();
        t_abort_stall();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule